// File: doc/BRIEF.md
# PC Card Host Strobe Sequencer

This block generates the host-side control strobes for one transfer to a removable card. A request carries an address, a direction, a target space (common memory, attribute memory or I/O), a socket number and a width. The block then drives the strobes on the card side through a fixed timing sequence. First the address is set up, then a strobe is held for at least a programmed number of cycles, and then the address is held after the strobe is released. Memory reads use the output-enable strobe and memory writes use the write-enable strobe. I/O transfers use their own read and write strobes instead.

The card can lengthen the strobe by holding its wait input low. For a 16-bit I/O request, the card's 16-bit acknowledge decides how the transfer is made. If the card acknowledges, the block runs one 16-bit cycle. If it does not, the block runs two 8-bit cycles on the low lane, low byte first. When the last cycle is finished, the block raises a one-cycle completion pulse and presents the read data, with 8-bit results right-aligned.

Top module: `pcc_strobe_seq`

## Requirements
- R1: After reset the block is idle. In the idle state `req_ready` is 1, all four strobes and both card enables are 1, `card_reg_n` is 1, `card_rd_nwr` is 1 and `done` is 0. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 again in the cycle where `done` is 1.
- R2: `card_rd_nwr` is 0 during every cycle of a write access, from the first setup cycle to the last hold cycle. It is 1 for reads and while idle.
- R3: During the strobe phase exactly one strobe is low, and no strobe is low outside it. `req_space` encoding: 0 = common memory, 1 = attribute memory, 2 = I/O, 3 = treated as common memory. The strobe used is `card_oe_n` for a memory read, `card_we_n` for a memory write, `card_ior_n` for an I/O read and `card_iow_n` for an I/O write.
- R4: `card_reg_n` is 0 for the whole of an attribute-space access and 1 otherwise. `card_sock` carries the socket latched at acceptance and keeps that value until the next request is accepted.
- R5: Each cycle has three phases: max(`cfg_setup`,1) setup cycles with a card enable low and no strobe, then the strobe, then max(`cfg_hold`,1) hold cycles. `done` is 1 for one cycle, in the cycle after the last hold cycle.
- R6: The strobe stays low for max(`cfg_strobe`,1) cycles. On top of that it stays low one more cycle for each clock edge, from the last minimum cycle onward, at which `card_wait_n` is sampled 0. While a strobe is low and `card_wait_n` is 0, the strobe is still low in the next cycle.
- R7: `card_ce_n[1]` enables the high lane (data bits 15:8) and `card_ce_n[0]` enables the low lane (bits 7:0). Both are active low. An 8-bit access to an even address gives 2'b10, with the byte on bits 7:0. An 8-bit access to an odd address gives 2'b01, with the byte on bits 15:8. A 16-bit memory access gives 2'b00 and forces address bit 0 to 0.
- R8: For a 16-bit I/O request, `card_io16_n` is sampled on the edge that ends the setup phase. If it is 0, one 16-bit cycle runs with `card_ce_n` = 2'b00.
- R9: If `card_io16_n` is 1 at that edge, two cycles run with `card_ce_n` = 2'b10 during each strobe. The first cycle uses address bit 0 = 0 and data bits 7:0. The second uses address bit 0 = 1 and data bits 15:8, both carried on the low lane. The read result is {second byte, first byte}.
- R10: For a read, `rdata` presents the data captured on the edge that ends each strobe while `done` is 1, and keeps it until the next read completes. An 8-bit result sits in bits 7:0 with bits 15:8 zero.
- R11: `card_addr` does not change from the start of a strobe through the end of the hold phase that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | AW | Card address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | Target space (0 common, 1 attribute, 2 I/O) |
| req_sock | input | 1 | Socket number |
| req_wide | input | 1 | 1 = 16-bit request |
| req_wdata | input | 2*LANE_W | Write data |
| cfg_setup | input | CW | Setup cycles |
| cfg_strobe | input | CW | Minimum strobe cycles |
| cfg_hold | input | CW | Hold cycles |
| card_wait_n | input | 1 | Card wait, active low |
| card_io16_n | input | 1 | Card 16-bit I/O acknowledge, active low |
| card_rdata | input | 2*LANE_W | Data bus from the card |
| card_addr | output | AW | Address to the card |
| card_wdata | output | 2*LANE_W | Data bus to the card, lane-placed |
| card_oe_n | output | 1 | Memory read strobe |
| card_we_n | output | 1 | Memory write strobe |
| card_ior_n | output | 1 | I/O read strobe |
| card_iow_n | output | 1 | I/O write strobe |
| card_ce_n | output | 2 | Lane card enables, bit 1 high lane |
| card_reg_n | output | 1 | Attribute-space select, active low |
| card_sock | output | 1 | Socket select |
| card_rd_nwr | output | 1 | Bus direction, 1 = read |
| done | output | 1 | Completion pulse |
| rdata | output | 2*LANE_W | Read result |

## Verification
The first setup cycle starts one edge after acceptance. The strobe follows after the setup count, and hold follows after the strobe count plus the number of wait-low samples. `done` arrives one cycle after the last hold cycle. The monitor samples every output on the falling edge. It splits the card-enable activity into sub-cycles, counting setup, strobe and hold cycles. A sub-cycle closes when the enables go high or the address changes. The monitor then compares these counts, and the values seen during the strobe, against the items the driver queued for that request. The card model releases wait on the falling edge of strobe cycle max(`cfg_strobe`,1)+W. This makes the expected stretch exactly W cycles. Read data is compared in the cycle where `done` is seen high.

// File: rtl/pcc_pkg.sv
// Shared types for the PC card strobe sequencer.
package pcc_pkg;
    typedef enum logic [1:0] {
        SP_COMMON = 2'd0,
        SP_ATTR   = 2'd1,
        SP_IO     = 2'd2,
        SP_RSVD   = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic oe_n;
        logic we_n;
        logic ior_n;
        logic iow_n;
    } strobe_t;
endpackage

// File: rtl/pcc_phase_timer.sv
// Down-counter that times one phase of an access.
// Assumes: load is pulsed on the edge that enters a phase with (length-1);
// expired is high in the last cycle of the phase.
module pcc_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R5
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pcc_strobe_dec.sv
// Picks which of the four strobes to drive low for the current phase.
// Assumes: only the strobe phase asserts a strobe; reserved space acts as common memory.
module pcc_strobe_dec
    import pcc_pkg::*;
(
    input  logic    active,
    input  space_e  space,
    input  logic    write,
    output strobe_t strb
);
    logic is_io;

    // Separate memory and I/O strobe pairs, chosen by space and direction.
    always_comb begin
        is_io      = (space == SP_IO);
        strb.oe_n  = !(active && !is_io && !write);
        strb.we_n  = !(active && !is_io &&  write);
        strb.ior_n = !(active &&  is_io && !write);
        strb.iow_n = !(active &&  is_io &&  write);
    end
endmodule

// File: rtl/pcc_lane_map.sv
// Byte-lane enable and data placement for one card cycle, plus read capture.
// Assumes: full16 and split are never both set; in split mode both bytes
// travel on the low lane, low byte first.
module pcc_lane_map #(
    parameter int LANE_W = 8,
    localparam int DW = 2 * LANE_W
) (
    input  logic          engaged,
    input  logic          full16,
    input  logic          split,
    input  logic          second,
    input  logic          odd,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] prev_rdata,
    output logic [1:0]    ce_n,
    output logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] cap_data
);
    localparam logic [LANE_W-1:0] ZB = '0;

    // Lane enables and outgoing data for the active cycle.
    always_comb begin
        ce_n      = 2'b11;
        bus_wdata = '0;
        if (engaged) begin
            if (full16) begin
                ce_n      = 2'b00;
                bus_wdata = wdata;
            end else if (split) begin
                ce_n      = 2'b10;
                bus_wdata = {ZB, second ? wdata[DW-1:LANE_W] : wdata[LANE_W-1:0]};
            end else if (odd) begin
                ce_n      = 2'b01;
                bus_wdata = {wdata[LANE_W-1:0], ZB};
            end else begin
                ce_n      = 2'b10;
                bus_wdata = {ZB, wdata[LANE_W-1:0]};
            end
        end
    end

    // Read result to store at the end of the strobe.
    always_comb begin
        if (full16)
            cap_data = bus_rdata;
        else if (split)
            cap_data = second ? {bus_rdata[LANE_W-1:0], prev_rdata[LANE_W-1:0]}
                              : {ZB, bus_rdata[LANE_W-1:0]};
        else if (odd)
            cap_data = {ZB, bus_rdata[DW-1:LANE_W]};
        else
            cap_data = {ZB, bus_rdata[LANE_W-1:0]};
    end
endmodule

// File: rtl/pcc_strobe_seq.sv
// PC card host strobe sequencer: setup, strobe (wait-stretched), hold, and an
// optional second 8-bit cycle when a 16-bit I/O request is not acknowledged.
// Assumes: config inputs are stable while busy; card inputs are synchronous.
module pcc_strobe_seq
    import pcc_pkg::*;
#(
    parameter int AW = 26,
    parameter int CW = 4,
    parameter int LANE_W = 8,
    localparam int DW = 2 * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic [1:0]    req_space,
    input  logic          req_sock,
    input  logic          req_wide,
    input  logic [DW-1:0] req_wdata,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_strobe,
    input  logic [CW-1:0] cfg_hold,
    input  logic          card_wait_n,
    input  logic          card_io16_n,
    input  logic [DW-1:0] card_rdata,
    output logic [AW-1:0] card_addr,
    output logic [DW-1:0] card_wdata,
    output logic          card_oe_n,
    output logic          card_we_n,
    output logic          card_ior_n,
    output logic          card_iow_n,
    output logic [1:0]    card_ce_n,
    output logic          card_reg_n,
    output logic          card_sock,
    output logic          card_rd_nwr,
    output logic          done,
    output logic [DW-1:0] rdata
);
    phase_e        phase;
    space_e        sp_q;
    logic [AW-1:0] a_q;
    logic [DW-1:0] wd_q, rd_q, cap_data;
    logic          wr_q, sock_q, wide_q, split_q, second_q, done_q;
    logic          tmr_load, tmr_zero, engaged, full16;
    logic [CW-1:0] tmr_val;
    strobe_t       strb;

    function automatic logic [CW-1:0] len_m1(input logic [CW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    // Choose when the phase timer reloads and with which length.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase)
            PH_IDLE:   if (req_valid) begin tmr_load = 1'b1; tmr_val = len_m1(cfg_setup); end
            PH_SETUP:  if (tmr_zero) begin tmr_load = 1'b1; tmr_val = len_m1(cfg_strobe); end
            PH_STROBE: if (tmr_zero && card_wait_n) begin tmr_load = 1'b1; tmr_val = len_m1(cfg_hold); end
            PH_HOLD:   if (tmr_zero && split_q && !second_q) begin tmr_load = 1'b1; tmr_val = len_m1(cfg_setup); end
            default:   tmr_load = 1'b0;
        endcase
    end

    pcc_phase_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
    );

    // Access sequencer: latch request, walk phases, capture data, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            sp_q     <= SP_COMMON;
            a_q      <= '0;
            wd_q     <= '0;
            rd_q     <= '0;
            wr_q     <= 1'b0;
            sock_q   <= 1'b0;
            wide_q   <= 1'b0;
            split_q  <= 1'b0;
            second_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: if (req_valid) begin
                    a_q      <= req_addr;
                    wr_q     <= req_write;
                    sp_q     <= space_e'(req_space);
                    sock_q   <= req_sock;
                    wide_q   <= req_wide;
                    wd_q     <= req_wdata;
                    split_q  <= 1'b0;
                    second_q <= 1'b0;
                    phase    <= PH_SETUP;
                end
                PH_SETUP: if (tmr_zero) begin
                    phase <= PH_STROBE;
                    if (wide_q && sp_q == SP_IO && !second_q)
                        split_q <= card_io16_n;
                end
                PH_STROBE: if (tmr_zero && card_wait_n) begin
                    phase <= PH_HOLD;
                    if (!wr_q)
                        rd_q <= cap_data;
                end
                PH_HOLD: if (tmr_zero) begin
                    if (split_q && !second_q) begin
                        second_q <= 1'b1;
                        phase    <= PH_SETUP;
                    end else begin
                        phase  <= PH_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign engaged = (phase != PH_IDLE);
    assign full16  = wide_q && !split_q;

    pcc_strobe_dec u_dec (
        .active(phase == PH_STROBE), .space(sp_q), .write(wr_q), .strb(strb)
    );

    pcc_lane_map #(.LANE_W(LANE_W)) u_lane (
        .engaged(engaged), .full16(full16), .split(split_q), .second(second_q),
        .odd(a_q[0]), .wdata(wd_q), .bus_rdata(card_rdata), .prev_rdata(rd_q),
        .ce_n(card_ce_n), .bus_wdata(card_wdata), .cap_data(cap_data)
    );

    assign card_addr   = {a_q[AW-1:1], wide_q ? second_q : a_q[0]};
    assign card_oe_n   = strb.oe_n;
    assign card_we_n   = strb.we_n;
    assign card_ior_n  = strb.ior_n;
    assign card_iow_n  = strb.iow_n;
    assign card_reg_n  = !(engaged && sp_q == SP_ATTR);
    assign card_sock   = sock_q;
    assign card_rd_nwr = engaged ? !wr_q : 1'b1;
    assign req_ready   = (phase == PH_IDLE);
    assign done        = done_q;
    assign rdata       = rd_q;

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~{card_oe_n, card_we_n, card_ior_n, card_iow_n}) <= 1);
    // R7
    strobe_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_oe_n && card_we_n && card_ior_n && card_iow_n) |-> (card_ce_n != 2'b11));
    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(card_oe_n && card_we_n && card_ior_n && card_iow_n) && !card_wait_n)
        |=> !(card_oe_n && card_we_n && card_ior_n && card_iow_n));
    // R11
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_oe_n && card_we_n && card_ior_n && card_iow_n) |=> $stable(card_addr));
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
    // R2
    dir_engaged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !card_rd_nwr |-> (card_ce_n != 2'b11));
endmodule

// File: tb/sim_pcc_strobe_seq.sv
// Scoreboard bench: driver queues expected card cycles, monitor measures them.
module sim_pcc_strobe_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [25:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_space = 2'd0;
    logic        req_sock = 1'b0;
    logic        req_wide = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  cfg_setup = 4'd1, cfg_strobe = 4'd1, cfg_hold = 4'd1;
    logic        card_wait_n = 1'b1;
    logic        card_io16_n = 1'b1;
    logic [15:0] card_rdata;
    logic [25:0] card_addr;
    logic [15:0] card_wdata;
    logic        card_oe_n, card_we_n, card_ior_n, card_iow_n;
    logic [1:0]  card_ce_n;
    logic        card_reg_n, card_sock, card_rd_nwr, done;
    logic [15:0] rdata;

    typedef struct {
        logic [3:0]  strb;
        logic [1:0]  ce;
        logic [25:0] addr;
        bit          chk_wd;
        logic [15:0] wd;
        int          su;
        int          st;
        int          ho;
        logic        rdnwr;
        logic        regn;
        logic        sock;
    } seg_t;

    seg_t        seg_q[$];
    logic [15:0] rd_exp_q[$];
    bit          rd_chk_q[$];

    int nchk = 0, nerr = 0, cyc = 0;
    int eff_st = 1, wext = 0, wc = 0;

    always #10 clk = ~clk;

    pcc_strobe_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_space(req_space),
        .req_sock(req_sock), .req_wide(req_wide), .req_wdata(req_wdata),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .card_wait_n(card_wait_n), .card_io16_n(card_io16_n), .card_rdata(card_rdata),
        .card_addr(card_addr), .card_wdata(card_wdata), .card_oe_n(card_oe_n),
        .card_we_n(card_we_n), .card_ior_n(card_ior_n), .card_iow_n(card_iow_n),
        .card_ce_n(card_ce_n), .card_reg_n(card_reg_n), .card_sock(card_sock),
        .card_rd_nwr(card_rd_nwr), .done(done), .rdata(rdata)
    );

    // Card model: data depends on address; wait released after eff_st+wext strobe cycles.
    assign card_rdata = {card_addr[7:0] ^ 8'h5A, card_addr[7:0]};

    always @(negedge clk) begin
        if (!(card_oe_n && card_we_n && card_ior_n && card_iow_n)) begin
            wc = wc + 1;
            card_wait_n = (wc >= eff_st + wext);
        end else begin
            wc = 0;
            card_wait_n = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: split card activity into sub-cycles, compare with queue.
    bit          m_open = 0;
    logic [25:0] m_addr;
    int          m_su, m_st, m_ho;
    logic [3:0]  m_strb;
    logic [1:0]  m_ce;
    logic [15:0] m_wd;
    logic        m_rdnwr, m_regn, m_sock;

    always @(negedge clk) begin
        if (rst_n) begin
            if (m_open && (card_ce_n == 2'b11 || card_addr != m_addr)) begin
                m_open = 0;
                if (seg_q.size() == 0) begin
                    chk(0, "R5 unexpected card cycle", m_addr, 0);
                end else begin
                    seg_t e;
                    e = seg_q.pop_front();
                    chk(m_su == e.su, "R5 setup cycles", m_su, e.su);
                    chk(m_st == e.st, "R6 strobe cycles", m_st, e.st);
                    chk(m_ho == e.ho, "R5 hold cycles", m_ho, e.ho);
                    chk(m_strb == e.strb, "R3 strobe select", m_strb, e.strb);
                    chk(m_ce == e.ce, "R7 R8 R9 lane enables", m_ce, e.ce);
                    chk(m_addr == e.addr, "R11 address", m_addr, e.addr);
                    chk(m_rdnwr == e.rdnwr, "R2 direction", m_rdnwr, e.rdnwr);
                    chk(m_regn == e.regn, "R4 register select", m_regn, e.regn);
                    chk(m_sock == e.sock, "R4 socket select", m_sock, e.sock);
                    if (e.chk_wd)
                        chk(m_wd == e.wd, "R7 R9 write lanes", m_wd, e.wd);
                end
            end
            if (!m_open && card_ce_n != 2'b11) begin
                m_open = 1; m_addr = card_addr; m_su = 0; m_st = 0; m_ho = 0;
            end
            if (m_open) begin
                if (!(card_oe_n && card_we_n && card_ior_n && card_iow_n)) begin
                    m_st++;
                    m_strb = {card_oe_n, card_we_n, card_ior_n, card_iow_n};
                    m_ce = card_ce_n; m_wd = card_wdata;
                    m_rdnwr = card_rd_nwr; m_regn = card_reg_n; m_sock = card_sock;
                end else if (m_st == 0) m_su++;
                else m_ho++;
            end
            if (done) begin
                chk(req_ready == 1'b1, "R1 ready at done", req_ready, 1);
                if (rd_exp_q.size() == 0) chk(0, "R5 unexpected done", 1, 0);
                else begin
                    logic [15:0] ex;
                    bit rc;
                    ex = rd_exp_q.pop_front();
                    rc = rd_chk_q.pop_front();
                    if (rc) chk(rdata == ex, "R10 read data", rdata, ex);
                end
            end
        end
    end

    // Driver: queue expectations, present one request, wait for completion.
    task automatic xfer(input logic [25:0] addr, input bit wr, input logic [1:0] sp,
                        input bit sock, input bit wide, input logic [15:0] wd,
                        input bit ack16, input int w);
        seg_t s;
        bit split, full;
        logic [25:0] a0;
        int ss, hh;
        ss = (cfg_setup == 0) ? 1 : int'(cfg_setup);
        hh = (cfg_hold == 0) ? 1 : int'(cfg_hold);
        eff_st = (cfg_strobe == 0) ? 1 : int'(cfg_strobe);
        wext = w;
        card_io16_n = !ack16;
        split = wide && sp == 2'd2 && !ack16;
        full = wide && !split;
        a0 = {addr[25:1], 1'b0};
        s.strb = (sp == 2'd2) ? (wr ? 4'b1110 : 4'b1101) : (wr ? 4'b1011 : 4'b0111);
        s.chk_wd = wr; s.su = ss; s.st = eff_st + w; s.ho = hh;
        s.rdnwr = !wr; s.regn = (sp != 2'd1); s.sock = sock;
        if (full) begin
            s.ce = 2'b00; s.addr = a0; s.wd = wd; seg_q.push_back(s);
            rd_exp_q.push_back({a0[7:0] ^ 8'h5A, a0[7:0]});
        end else if (split) begin
            s.ce = 2'b10; s.addr = a0; s.wd = {8'h00, wd[7:0]}; seg_q.push_back(s);
            s.addr = a0 | 26'd1; s.wd = {8'h00, wd[15:8]}; seg_q.push_back(s);
            rd_exp_q.push_back({a0[7:0] | 8'd1, a0[7:0]});
        end else if (addr[0]) begin
            s.ce = 2'b01; s.addr = addr; s.wd = {wd[7:0], 8'h00}; seg_q.push_back(s);
            rd_exp_q.push_back({8'h00, addr[7:0] ^ 8'h5A});
        end else begin
            s.ce = 2'b10; s.addr = addr; s.wd = {8'h00, wd[7:0]}; seg_q.push_back(s);
            rd_exp_q.push_back({8'h00, addr[7:0]});
        end
        rd_chk_q.push_back(!wr);
        req_addr = addr; req_write = wr; req_space = sp; req_sock = sock;
        req_wide = wide; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            nerr++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk({card_oe_n, card_we_n, card_ior_n, card_iow_n} == 4'hF, "R1 strobes idle",
            {card_oe_n, card_we_n, card_ior_n, card_iow_n}, 4'hF);
        chk(card_ce_n == 2'b11, "R1 enables idle", card_ce_n, 2'b11);
        chk(card_reg_n && card_rd_nwr && !done, "R1 reg/dir/done idle",
            {card_reg_n, card_rd_nwr, done}, 3'b110);

        cfg_setup = 4'd2; cfg_strobe = 4'd3; cfg_hold = 4'd1;
        xfer(26'h0000010, 0, 2'd0, 0, 0, 16'h0000, 0, 0);   // R7 common read even
        xfer(26'h0000023, 0, 2'd0, 0, 0, 16'h0000, 0, 0);   // R7 common read odd
        xfer(26'h0000045, 1, 2'd0, 1, 1, 16'hBEEF, 0, 0);   // R7 wide write, bit0 forced
        xfer(26'h0000104, 0, 2'd1, 1, 0, 16'h0000, 0, 0);   // R4 attribute read socket 1
        xfer(26'h0000107, 1, 2'd1, 0, 0, 16'h00C3, 0, 0);   // R4 attribute write odd
        xfer(26'h0000300, 0, 2'd2, 0, 0, 16'h0000, 0, 0);   // R3 I/O read narrow
        xfer(26'h0000301, 1, 2'd2, 1, 0, 16'h0077, 0, 0);   // R3 I/O write narrow
        xfer(26'h0000310, 0, 2'd2, 0, 1, 16'h0000, 1, 0);   // R8 I/O wide acknowledged
        cfg_hold = 4'd2;
        xfer(26'h0000320, 1, 2'd2, 1, 1, 16'h1234, 0, 0);   // R9 split write
        xfer(26'h0000331, 0, 2'd2, 0, 1, 16'h0000, 0, 2);   // R9 split read with wait
        xfer(26'h0000040, 0, 2'd0, 0, 0, 16'h0000, 0, 3);   // R6 wait stretch 3
        cfg_setup = 4'd0; cfg_strobe = 4'd0; cfg_hold = 4'd0;
        xfer(26'h0000052, 0, 2'd0, 1, 1, 16'h0000, 0, 1);   // R5 zero counts act as 1
        xfer(26'h0000053, 1, 2'd3, 0, 0, 16'h00AA, 0, 0);   // R3 reserved space as common
        cfg_setup = 4'd5; cfg_strobe = 4'd4; cfg_hold = 4'd3;
        xfer(26'h0000200, 1, 2'd1, 1, 1, 16'h55AA, 0, 5);   // R6 R5 long phases
        repeat (5) @(negedge clk);
        chk(seg_q.size() == 0, "R5 all card cycles seen", seg_q.size(), 0);
        chk(card_sock == 1'b1, "R4 socket held after access", card_sock, 1);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule